// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register side of a memory-mapped GPIO controller with four banks of 32 pins. A simple register bus (address, write enable, write data, read enable, read data) reaches per-bank direction, output-latch, rising-enable, falling-enable and two alternate-function words.

Set and clear addresses modify the output latch without a read-modify-write. A level address returns, per pin, either the driven latch bit or the sampled input bit, selected by the pin's direction. Edge-status state lives in a neighbouring edge-detect block. This interface passes that block the enable and direction vectors, reads its status vector, and sends it a per-bit clear strobe.

The alternate-function words are plain storage. Pad electrics and pin multiplexing live elsewhere.

Top module: `gpio_regif`

## Requirements
- R1: After reset every stored register is zero. `pin_out_o`, `dir_o`, `rise_en_o`, `fall_en_o`, `edge_clr_o`, `rdata_o`, `rd_err_o` and `lvl_rd_o` are all zero.
- R2: Kind index k (0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge status) of bank b is at byte offset 12k+4b for banks 0 to 2, and at 0x100+12k for bank 3. Alternate-function words of bank b are at 0x54+8b (low) and 0x58+8b (high). Direction, rising-enable, falling-enable and both alternate-function words read back what was last written. Direction and the two enables appear on `dir_o`, `rise_en_o` and `fall_en_o`, with pin 32b+i at bit 32b+i.
- R3: A write to a set offset ORs the data into that bank's output latch. A write to a clear offset clears the latch bits that are 1 in the data. Both offsets read as zero.
- R4: `pin_out_o` equals the output latch ANDed with the direction bits, so a pin whose direction bit is 0 drives 0.
- R5: A level read returns the latch bit where direction is 1, and the `pin_in_i` bit where direction is 0.
- R6: `lvl_rd_o` is 1 for exactly the one cycle in which the data of a level read is presented, and 0 otherwise.
- R7: An edge-status read returns that bank's slice of `edge_stat_i`. An edge-status write drives the write data onto that bank's slice of `edge_clr_o` in the same cycle. All other bits of `edge_clr_o` stay 0, and so does the whole vector in every other cycle.
- R8: Offsets at or above 0x200 read as zero without an error flag and leave all state unchanged when written.
- R9: An offset below 0x200 that matches no register (including any offset not a multiple of 4) reads as zero and raises `rd_err_o` for one cycle. A write there changes no state.
- R10: Read data appears on `rdata_o` in the cycle after `re_i` is sampled high. `rdata_o` is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (12) | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Registered read data |
| rd_err_o | output | 1 | Unmapped-offset read flag |
| lvl_rd_o | output | 1 | Level-read notify pulse |
| pin_in_i | input | 128 | Sampled input pin levels |
| pin_out_o | output | 128 | Driven pin values |
| dir_o | output | 128 | Direction bits (1 = output) |
| rise_en_o | output | 128 | Rising-edge enables to edge block |
| fall_en_o | output | 128 | Falling-edge enables to edge block |
| edge_stat_i | input | 128 | Status vector from edge block |
| edge_clr_o | output | 128 | Status clear strobe to edge block |

## Verification
The assertions assume that read and write never target the same cycle with conflicting intent. They also assume that `re_i` and `we_i` are synchronous to `clk_i` and held at 0 during reset. The bench meets this by issuing one access per task call, always from the falling edge, with the other enable low. Expected values come from an arithmetic offset decode and a register model kept in the bench. Every word offset below 0x200 is both written and read, along with a few misaligned and out-of-range offsets.

// File: rtl/gpio_regif_pkg.sv
package gpio_regif_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_LVL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_EDGE, K_AFL, K_AFH
  } reg_kind_e;

  localparam int unsigned N_MAIN    = 7;     // level..edge kinds
  localparam int unsigned MAIN_STEP = 12;    // bytes between kinds
  localparam int unsigned LOW_BANKS = 3;     // banks in the low region
  localparam int unsigned HI_BASE   = 'h100; // region of the remaining banks
  localparam int unsigned AF_BASE   = 'h54;
  localparam int unsigned MAP_TOP   = 'h200;

  function automatic logic [8:0] main_off(int unsigned k, int unsigned b);
    if (b < LOW_BANKS) return 9'(MAIN_STEP * k + 4 * b);
    return 9'(HI_BASE + MAIN_STEP * k + 4 * (b - LOW_BANKS));
  endfunction

  function automatic logic [8:0] af_off(int unsigned b, int unsigned hi);
    return 9'(AF_BASE + 8 * b + 4 * hi);
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_regif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [BW-1:0]     bank_o,
  output logic              oob_o
);

  always_comb begin
    kind_o = K_NONE;
    bank_o = '0;
    oob_o  = (addr_i[ADDR_W-1:9] != '0);
    if (!oob_o) begin
      for (int unsigned b = 0; b < NUM_BANKS; b++) begin
        for (int unsigned k = 0; k < N_MAIN; k++) begin
          if (addr_i[8:0] == main_off(k, b)) begin
            kind_o = reg_kind_e'(k + 1);
            bank_o = BW'(b);
          end
        end
        if (addr_i[8:0] == af_off(b, 0)) begin
          kind_o = K_AFL;
          bank_o = BW'(b);
        end
        if (addr_i[8:0] == af_off(b, 1)) begin
          kind_o = K_AFH;
          bank_o = BW'(b);
        end
      end
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_we_i,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         rise_we_i,
  input  logic         fall_we_i,
  input  logic         afl_we_i,
  input  logic         afh_we_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] olat_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] afl_o,
  output logic [W-1:0] afh_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      olat_o <= '0;
      rise_o <= '0;
      fall_o <= '0;
      afl_o  <= '0;
      afh_o  <= '0;
    end else begin
      if (dir_we_i)  dir_o  <= wdata_i;
      if (rise_we_i) rise_o <= wdata_i;
      if (fall_we_i) fall_o <= wdata_i;
      if (afl_we_i)  afl_o  <= wdata_i;
      if (afh_we_i)  afh_o  <= wdata_i;
      if (set_we_i)      olat_o <= olat_o | wdata_i;
      else if (clr_we_i) olat_o <= olat_o & ~wdata_i;
    end
  end

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_regif_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned W         = 32,
  localparam int unsigned BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        re_i,
  input  reg_kind_e                   kind_i,
  input  logic [BW-1:0]               bank_i,
  input  logic                        oob_i,
  input  logic [NUM_BANKS-1:0][W-1:0] dir_i,
  input  logic [NUM_BANKS-1:0][W-1:0] olat_i,
  input  logic [NUM_BANKS-1:0][W-1:0] rise_i,
  input  logic [NUM_BANKS-1:0][W-1:0] fall_i,
  input  logic [NUM_BANKS-1:0][W-1:0] afl_i,
  input  logic [NUM_BANKS-1:0][W-1:0] afh_i,
  input  logic [NUM_BANKS-1:0][W-1:0] pin_in_i,
  input  logic [NUM_BANKS-1:0][W-1:0] edge_stat_i,
  output logic [W-1:0]                rdata_o,
  output logic                        err_o,
  output logic                        lvl_o
);

  logic [W-1:0] rd_val;
  logic         is_lvl, is_miss;

  always_comb begin
    rd_val  = '0;
    is_lvl  = 1'b0;
    is_miss = 1'b0;
    case (kind_i)
      K_LVL: begin
        rd_val = (olat_i[bank_i] & dir_i[bank_i]) | (pin_in_i[bank_i] & ~dir_i[bank_i]);
        is_lvl = 1'b1;
      end
      K_DIR:  rd_val = dir_i[bank_i];
      K_RISE: rd_val = rise_i[bank_i];
      K_FALL: rd_val = fall_i[bank_i];
      K_EDGE: rd_val = edge_stat_i[bank_i];
      K_AFL:  rd_val = afl_i[bank_i];
      K_AFH:  rd_val = afh_i[bank_i];
      K_SET, K_CLR: rd_val = '0;   // write-only
      default: is_miss = !oob_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      lvl_o   <= 1'b0;
    end else begin
      rdata_o <= re_i ? rd_val : '0;
      err_o   <= re_i & is_miss;
      lvl_o   <= re_i & is_lvl;
    end
  end

endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_regif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned W         = 32,
  localparam int unsigned NPINS    = NUM_BANKS * W,
  localparam int unsigned BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              re_i,
  output logic [W-1:0]      rdata_o,
  output logic              rd_err_o,
  output logic              lvl_rd_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  input  logic [NPINS-1:0]  edge_stat_i,
  output logic [NPINS-1:0]  edge_clr_o
);

  reg_kind_e   kind;
  logic [BW-1:0] bank;
  logic        oob;

  logic [NUM_BANKS-1:0][W-1:0] dir_q, olat_q, rise_q, fall_q, afl_q, afh_q;
  logic [NUM_BANKS-1:0][W-1:0] pin_in_b, edge_stat_b, edge_clr_b, drive_b;

  assign pin_in_b    = pin_in_i;
  assign edge_stat_b = edge_stat_i;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .bank_o (bank),
    .oob_o  (oob)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = we_i && (bank == BW'(b));

    gpio_bank_regs #(.W(W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (wdata_i),
      .dir_we_i  (sel && kind == K_DIR),
      .set_we_i  (sel && kind == K_SET),
      .clr_we_i  (sel && kind == K_CLR),
      .rise_we_i (sel && kind == K_RISE),
      .fall_we_i (sel && kind == K_FALL),
      .afl_we_i  (sel && kind == K_AFL),
      .afh_we_i  (sel && kind == K_AFH),
      .dir_o     (dir_q[b]),
      .olat_o    (olat_q[b]),
      .rise_o    (rise_q[b]),
      .fall_o    (fall_q[b]),
      .afl_o     (afl_q[b]),
      .afh_o     (afh_q[b])
    );

    assign edge_clr_b[b] = (sel && kind == K_EDGE) ? wdata_i : '0;
    assign drive_b[b]    = olat_q[b] & dir_q[b];
  end

  gpio_rd_path #(.NUM_BANKS(NUM_BANKS), .W(W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .re_i        (re_i),
    .kind_i      (kind),
    .bank_i      (bank),
    .oob_i       (oob),
    .dir_i       (dir_q),
    .olat_i      (olat_q),
    .rise_i      (rise_q),
    .fall_i      (fall_q),
    .afl_i       (afl_q),
    .afh_i       (afh_q),
    .pin_in_i    (pin_in_b),
    .edge_stat_i (edge_stat_b),
    .rdata_o     (rdata_o),
    .err_o       (rd_err_o),
    .lvl_o       (lvl_rd_o)
  );

  assign pin_out_o  = drive_b;
  assign dir_o      = dir_q;
  assign rise_en_o  = rise_q;
  assign fall_en_o  = fall_q;
  assign edge_clr_o = edge_clr_b;

endmodule

// File: rtl/gpio_regif_chk.sv
module gpio_regif_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned W      = 32,
  parameter int unsigned NPINS  = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [W-1:0]      rdata_o,
  input logic              rd_err_o,
  input logic              lvl_rd_o,
  input logic [NPINS-1:0]  pin_out_o,
  input logic [NPINS-1:0]  dir_o,
  input logic [NPINS-1:0]  rise_en_o,
  input logic [NPINS-1:0]  fall_en_o,
  input logic [NPINS-1:0]  edge_clr_o
);

  // R4
  drive_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~dir_o) == '0);

  // R6
  notify_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_rd_o |-> ($past(re_i) && !rd_err_o));

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> ($past(re_i) && $past(addr_i) < ADDR_W'('h200)));

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(re_i) |-> (rdata_o == '0));

  // R7
  clr_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_clr_o != '0) |-> we_i);

  // R8
  oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'('h200)) |=>
      ($stable(dir_o) && $stable(pin_out_o) && $stable(rise_en_o) && $stable(fall_en_o)));

endmodule

bind gpio_regif gpio_regif_chk #(.ADDR_W(ADDR_W), .W(W), .NPINS(NPINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .rdata_o    (rdata_o),
  .rd_err_o   (rd_err_o),
  .lvl_rd_o   (lvl_rd_o),
  .pin_out_o  (pin_out_o),
  .dir_o      (dir_o),
  .rise_en_o  (rise_en_o),
  .fall_en_o  (fall_en_o),
  .edge_clr_o (edge_clr_o)
);

// File: tb/gpio_regif_tb.sv
module gpio_regif_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic         re = 1'b0;
  logic [31:0]  rdata;
  logic         rd_err, lvl_rd;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, dir_v, rise_v, fall_v, edge_clr;
  logic [127:0] edge_stat = '0;

  int nchk = 0;
  int nerr = 0;

  logic [31:0] m_dir[4], m_out[4], m_rise[4], m_fall[4], m_afl[4], m_afh[4];

  always #5 clk = ~clk;

  gpio_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .rd_err_o(rd_err), .lvl_rd_o(lvl_rd),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .dir_o(dir_v), .rise_en_o(rise_v),
    .fall_en_o(fall_v), .edge_stat_i(edge_stat), .edge_clr_o(edge_clr)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kind: 0 level,1 dir,2 set,3 clear,4 rise,5 fall,6 edge,7 af low,8 af high
  function automatic bit bdec(int a, output int kind, output int bank);
    kind = -1;
    bank = 0;
    if (a % 4 != 0 || a >= 'h200) return 1'b0;
    if (a < 'h54) begin kind = (a / 4) / 3; bank = (a / 4) % 3; return 1'b1; end
    if (a < 'h74) begin kind = 7 + ((a - 'h54) / 4) % 2; bank = ((a - 'h54) / 4) / 2; return 1'b1; end
    if (a >= 'h100 && a < 'h154 && (a - 'h100) % 12 == 0) begin
      kind = (a - 'h100) / 12; bank = 3; return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_val(int kind, int b);
    case (kind)
      0: return (m_out[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b]);
      1: return m_dir[b];
      4: return m_rise[b];
      5: return m_fall[b];
      6: return edge_stat[b*32 +: 32];
      7: return m_afl[b];
      8: return m_afh[b];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int kind, bit mapped);
    if (!mapped) return "R9";
    case (kind)
      0: return "R5";
      2, 3: return "R3";
      6: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic wr(int a, logic [31:0] d);
    int k, b;
    bit m;
    logic [127:0] exp_clr;
    m = bdec(a, k, b);
    @(negedge clk);
    addr = 12'(a); wdata = d; we = 1'b1;
    #2;
    exp_clr = '0;
    if (m && k == 6) exp_clr[b*32 +: 32] = d;
    chk("R7 clear strobe", edge_clr, exp_clr);
    @(negedge clk);
    we = 1'b0;
    if (m) begin
      case (k)
        1: m_dir[b]  = d;
        2: m_out[b]  = m_out[b] | d;
        3: m_out[b]  = m_out[b] & ~d;
        4: m_rise[b] = d;
        5: m_fall[b] = d;
        7: m_afl[b]  = d;
        8: m_afh[b]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(int a);
    int k, b;
    bit m;
    logic [31:0] ev;
    m = bdec(a, k, b);
    ev = m ? exp_val(k, b) : '0;
    @(negedge clk);
    addr = 12'(a); re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk(tag_of(k, m), rdata, ev);
    chk("R9 err flag", rd_err, (!m && a < 'h200));
    chk("R6 notify", lvl_rd, (m && k == 0));
  endtask

  task automatic chk_outs(string req);
    logic [127:0] e_dir, e_out, e_r, e_f;
    for (int b = 0; b < 4; b++) begin
      e_dir[b*32 +: 32] = m_dir[b];
      e_out[b*32 +: 32] = m_out[b] & m_dir[b];
      e_r[b*32 +: 32]   = m_rise[b];
      e_f[b*32 +: 32]   = m_fall[b];
    end
    chk({req, " dir"}, dir_v, e_dir);
    chk({req, " R4 drive"}, pin_out, e_out);
    chk({req, " rise"}, rise_v, e_r);
    chk({req, " fall"}, fall_v, e_f);
  endtask

  task automatic sweep_rd();
    for (int a = 0; a < 'h200; a += 4) rd(a);
    for (int a = 1; a < 'h80; a += 13) rd(a);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_dir[b] = '0; m_out[b] = '0; m_rise[b] = '0;
      m_fall[b] = '0; m_afl[b] = '0; m_afh[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", rdata, '0);
    chk("R1 err", rd_err, '0);
    chk("R1 notify", lvl_rd, '0);
    chk("R1 clr", edge_clr, '0);
    chk_outs("R1");
    sweep_rd();

    // write every word offset (mapped and unmapped, R9 writes ignored)
    for (int a = 0; a < 'h200; a += 4)
      wr(a, 32'(a) * 32'h9E37_79B1 ^ 32'h5A5A_C3C3);
    chk_outs("R2 R9");
    pin_in    = {32'hF0F0_1234, 32'h0FF0_8765, 32'hAAAA_5555, 32'h1357_9BDF};
    edge_stat = {32'h0000_0011, 32'h8000_0001, 32'hDEAD_BEEF, 32'h0123_4567};
    sweep_rd();

    // R3 set then clear on bank 1 (set 0x1C, clear 0x28, dir 0x10)
    wr('h010, 32'hFFFF_FFFF);
    wr('h028, 32'hFFFF_FFFF);
    chk_outs("R3 after clear");
    wr('h01C, 32'h00FF_00F0);
    wr('h01C, 32'h0000_0F0F);
    chk_outs("R3 after set");
    wr('h028, 32'h0000_00FF);
    chk_outs("R3 partial clear");
    rd('h004); rd('h01C); rd('h028);

    // R4 switch bank 1 pins to input: drive drops
    wr('h010, 32'h0000_FFFF);
    chk_outs("R4 dir change");
    pin_in = ~pin_in;
    rd('h004);

    // R8 out-of-range writes ignored, reads zero without error
    wr('h200, 32'hFFFF_FFFF);
    wr('h30C, 32'hFFFF_FFFF);
    wr('hFFC, 32'hFFFF_FFFF);
    chk_outs("R8");
    rd('h200); rd('h318); rd('hFFC);

    // R10 idle cycle gives zero data
    @(negedge clk);
    chk("R10 idle", rdata, '0);
    rd('h10C);
    @(negedge clk);
    chk("R10 after read", rdata, '0);

    sweep_rd();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1_000_000;
    nchk++;
    nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule